// File: doc/BRIEF.md
# Three-Byte Serial ADC Read Sequencer

This block is the master side of one read from a dual-input 12-bit serial converter over a byte-oriented SPI link. On a start request it pulls chip select low, produces a serial clock divided down from the system clock, and sends a 24-bit command. The command opens with seven zero bits, then a start bit, then three configuration bits. Because of that padding, the returned null bit and the top four result bits sit at the end of the second byte, and the low eight result bits fill the third byte.

After the last clock the block releases chip select. It then shows the 12-bit result, the input it was taken from, and a flag that is set when the returned null bit was not zero. A valid strobe marks that cycle. Two clock-polarity modes are offered: the clock idles low or idles high. In both modes data leaves the master on falling edges and the converter output is sampled on rising edges.

Top module: `adc3b_read_ctrl`

## Requirements
- R1: While chip select is low, exactly 24 rising SCLK edges occur, and chip select stays low from the first of them to the last.
- R2: MOSI, as seen at rising edges 1 to 24, carries zeros on edges 1-7, a one on edge 8, the single-ended flag on edge 9, the input select on edge 10, a one (MSB first) on edge 11 and zeros on edges 12-24. MOSI changes only while SCLK is low.
- R3: MISO is sampled on rising SCLK edges. result_o[11:0] equals the bits taken on rising edges 13 to 24, most significant first.
- R4: With cpol_i = 0 SCLK idles low, and with cpol_i = 1 it idles high, both before and after a frame. Both modes produce 24 rising edges and the same command and result.
- R5: Each SCLK half period lasts DIV_HALF system clocks. Chip select falls at least one half period before the first SCLK transition and rises at least one half period after the last one.
- R6: result_valid_o is high for exactly one system clock, the cycle right after chip select returns high. result_chan_o then equals the chan_i value captured with the start.
- R7: null_err_o is 1 exactly when the bit sampled on rising edge 12 was 1.
- R8: A start request while busy_o is high starts no new frame and does not change the captured input select.
- R9: busy_o is high from the cycle chip select falls through the valid cycle, and low in the cycle after it.
- R10: During reset, csn_o is high and busy_o and result_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one conversion read |
| chan_i | input | 1 | Input select (odd/sign bit) |
| single_i | input | 1 | 1 = single-ended, 0 = differential |
| cpol_i | input | 1 | 0 = SCLK idles low, 1 = SCLK idles high |
| sclk_o | output | 1 | Serial clock to converter |
| csn_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Command data to converter |
| miso_i | input | 1 | Data from converter |
| busy_o | output | 1 | Frame in progress |
| result_o | output | 12 | Converted value |
| result_valid_o | output | 1 | One-cycle result strobe |
| result_chan_o | output | 1 | Input select the result belongs to |
| null_err_o | output | 1 | Returned null bit was not zero |

## Verification
The hardest case to reach is a second start request arriving in the middle of a frame. It has to come with a different input select, and the bench must then show that neither the frame length nor the reported channel changed. The bench raises such a request dozens of cycles into a frame, lets the frame finish, and then watches the idle line for a chip-select fall that must not come. A behavioural converter model reacts to the real SCLK edges in both polarities, so a misaligned sample shows up as a wrong result. That model returns ones in the undefined bit slots, and on chosen vectors it returns a one in the null slot.

// File: rtl/adc3b_pkg.sv
package adc3b_pkg;

    localparam int FRAME_BITS = 24;
    localparam int RES_BITS   = 12;
    localparam int RX_KEEP    = RES_BITS + 1;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int START_POS  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_HOLD,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic single;
        logic chan;
        logic cpol;
    } req_cfg_t;

    typedef struct packed {
        logic [RES_BITS-1:0] data;
        logic                null_err;
        logic                chan;
    } read_result_t;

    // Command bit for zero-based frame position idx.
    function automatic logic cmd_bit(input logic [BIT_W-1:0] idx, input req_cfg_t cfg);
        logic b;
        case (idx)
            BIT_W'(START_POS):     b = 1'b1;
            BIT_W'(START_POS + 1): b = cfg.single;
            BIT_W'(START_POS + 2): b = cfg.chan;
            BIT_W'(START_POS + 3): b = 1'b1;
            default:               b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/adc3b_half_tick.sv
module adc3b_half_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5: the half-period counter never passes its terminal value
    a_r5_cnt_range: assert property (@(posedge clk) disable iff (rst) cnt <= LAST);

endmodule

// File: rtl/adc3b_sequencer.sv
module adc3b_sequencer
    import adc3b_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  req_cfg_t              cfg_in,
    input  logic                  tick,
    output seq_state_t            state,
    output logic [BIT_W-1:0]      bitn,
    output logic                  phase,
    output req_cfg_t              cfg,
    output logic                  sample_en,
    output logic                  load_res
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    assign sample_en = (state == ST_SHIFT) && tick && !phase;
    assign load_res  = (state == ST_HOLD) && tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            bitn  <= '0;
            phase <= 1'b0;
            cfg   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cfg   <= cfg_in;
                        bitn  <= '0;
                        phase <= 1'b0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    if (tick) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!phase) begin
                            phase <= 1'b1;
                        end else if (bitn == LAST_BIT) begin
                            state <= ST_HOLD;
                        end else begin
                            phase <= 1'b0;
                            bitn  <= bitn + 1'b1;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) state <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: hold phase is entered only after the final bit position
    a_r1_hold_after_last: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> (bitn == LAST_BIT));

endmodule

// File: rtl/adc3b_rx_shift.sv
module adc3b_rx_shift
    import adc3b_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_en,
    input  logic         miso,
    input  logic         load,
    input  logic         chan,
    output read_result_t res
);
    logic [RX_KEEP-1:0] rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx  <= '0;
            res <= '0;
        end else begin
            if (sample_en) rx <= {rx[RX_KEEP-2:0], miso};
            if (load) begin
                res.data     <= rx[RES_BITS-1:0];
                res.null_err <= rx[RES_BITS];
                res.chan     <= chan;
            end
        end
    end

    // R3: result register only moves on the load strobe
    a_r3_res_stable: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(res));

endmodule

// File: rtl/adc3b_read_ctrl.sv
module adc3b_read_ctrl
    import adc3b_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                chan_i,
    input  logic                single_i,
    input  logic                cpol_i,
    output logic                sclk_o,
    output logic                csn_o,
    output logic                mosi_o,
    input  logic                miso_i,
    output logic                busy_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                result_valid_o,
    output logic                result_chan_o,
    output logic                null_err_o
);
    seq_state_t       state;
    logic [BIT_W-1:0] bitn;
    logic             phase;
    req_cfg_t         cfg_in, cfg;
    logic             tick, sample_en, load_res, in_frame;
    read_result_t     res;

    assign cfg_in   = '{single: single_i, chan: chan_i, cpol: cpol_i};
    assign in_frame = (state == ST_SETUP) || (state == ST_SHIFT) || (state == ST_HOLD);

    adc3b_half_tick #(.DIV_HALF(DIV_HALF)) tick_i (
        .clk (clk),
        .rst (rst),
        .run (in_frame),
        .tick(tick)
    );

    adc3b_sequencer seq_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .cfg_in   (cfg_in),
        .tick     (tick),
        .state    (state),
        .bitn     (bitn),
        .phase    (phase),
        .cfg      (cfg),
        .sample_en(sample_en),
        .load_res (load_res)
    );

    adc3b_rx_shift rx_i (
        .clk      (clk),
        .rst      (rst),
        .sample_en(sample_en),
        .miso     (miso_i),
        .load     (load_res),
        .chan     (cfg.chan),
        .res      (res)
    );

    always_comb begin
        if (state == ST_SHIFT)  sclk_o = phase;
        else if (in_frame)      sclk_o = cfg.cpol;
        else                    sclk_o = cpol_i;
    end

    assign csn_o          = !in_frame;
    assign mosi_o         = in_frame ? cmd_bit(bitn, cfg) : 1'b0;
    assign busy_o         = (state != ST_IDLE);
    assign result_valid_o = (state == ST_DONE);
    assign result_o       = res.data;
    assign result_chan_o  = res.chan;
    assign null_err_o     = res.null_err;

    // R2: command data only moves while the clock is low
    a_r2_mosi_low_phase: assert property (@(posedge clk) disable iff (rst)
        (!csn_o && $past(!csn_o) && !$stable(mosi_o)) |-> !sclk_o);
    // R6: the strobe is a single cycle
    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |=> !result_valid_o);
    // R6: the strobe follows the chip-select release
    a_r6_valid_after_csn: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |-> (csn_o && $past(!csn_o)));
    // R8: a frame only opens from a non-busy state
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(csn_o) |-> !$past(busy_o));
    // R9: busy covers the whole chip-select window
    a_r9_busy_framed: assert property (@(posedge clk) disable iff (rst)
        !csn_o |-> busy_o);

endmodule

// File: tb/adc3b_read_ctrl_tb_top.sv
module adc3b_read_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DIVH       = 3;
    localparam int HALF_T     = DIVH * CLK_PERIOD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, chan_i = 1'b0, single_i = 1'b0, cpol_i = 1'b0;
    logic miso_i = 1'b0;
    logic sclk_o, csn_o, mosi_o, busy_o, result_valid_o, result_chan_o, null_err_o;
    logic [11:0] result_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc3b_read_ctrl #(.DIV_HALF(DIVH)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
        .single_i(single_i), .cpol_i(cpol_i), .sclk_o(sclk_o), .csn_o(csn_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .busy_o(busy_o), .result_o(result_o),
        .result_valid_o(result_valid_o), .result_chan_o(result_chan_o),
        .null_err_o(null_err_o)
    );

    // behavioural converter: returned bits for rising edges 1..24 at [23]..[0]
    logic [23:0] adc_frame = '0;
    logic [23:0] mosi_cap = '0;
    int  rcnt = 0;
    int  cs_falls = 0;
    time t_cs_fall = 0, t_cs_rise = 0, t_first = 0, t_last = 0, min_gap = 0;
    bit  seen_edge = 0;

    always @(negedge csn_o) begin
        rcnt = 0;
        cs_falls++;
        seen_edge = 0;
        t_cs_fall = $time;
        miso_i = adc_frame[23];
    end
    always @(posedge csn_o) t_cs_rise = $time;
    always @(posedge sclk_o) if (!csn_o) begin
        mosi_cap = {mosi_cap[22:0], mosi_o};
        rcnt++;
    end
    always @(negedge sclk_o) if (!csn_o && rcnt < 24) miso_i = adc_frame[23 - rcnt];
    always @(sclk_o) if (!csn_o) begin
        if (!seen_edge) t_first = $time;
        else if ($time - t_last < min_gap) min_gap = $time - t_last;
        seen_edge = 1;
        t_last = $time;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // {cpol, chan, single, null, result[11:0]}
    localparam logic [15:0] VEC [6] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 12'hA5C},
        {1'b0, 1'b1, 1'b1, 1'b0, 12'h000},
        {1'b1, 1'b0, 1'b0, 1'b0, 12'hFFF},
        {1'b1, 1'b1, 1'b0, 1'b0, 12'h3C9},
        {1'b0, 1'b1, 1'b0, 1'b1, 12'h801},
        {1'b1, 1'b0, 1'b1, 1'b1, 12'h17E}
    };

    task automatic wait_valid();
        int n = 0;
        while (!result_valid_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_one(input logic cp, input logic ch, input logic sg,
                           input logic nl, input logic [11:0] rv);
        logic [23:0] exp_cmd;
        adc_frame = {11'h7FF, nl, rv};
        exp_cmd   = {7'b0, 1'b1, sg, ch, 1'b1, 13'b0};
        min_gap   = 64'd1000000;
        @(negedge clk);
        cpol_i = cp; chan_i = ch; single_i = sg; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R9 busy at frame open", {30'b0, busy_o, csn_o}, 32'b10);
        wait_valid();
        chk("R6 valid seen with csn high", {30'b0, result_valid_o, csn_o}, 32'b11);
        chk("R9 busy in valid cycle", busy_o, 1);
        chk("R1 rising edges", rcnt, 24);
        chk("R2 command bits", mosi_cap, exp_cmd);
        chk("R3 result", result_o, rv);
        chk("R6 channel", result_chan_o, ch);
        chk("R7 null flag", null_err_o, nl);
        chk("R5 half period", (min_gap == HALF_T), 1);
        chk("R5 csn setup", (t_first - t_cs_fall >= HALF_T), 1);
        chk("R5 csn hold", (t_cs_rise - t_last >= HALF_T), 1);
        @(negedge clk);
        chk("R6 strobe one cycle", result_valid_o, 0);
        chk("R9 busy drops", busy_o, 0);
        chk("R4 idle level", sclk_o, cp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 csn in reset", csn_o, 1);
        chk("R10 busy in reset", busy_o, 0);
        chk("R10 valid in reset", result_valid_o, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 6; i++)
            run_one(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:0]);

        // R8: start request mid-frame with another channel
        begin
            int falls_before;
            adc_frame = {11'h7FF, 1'b0, 12'h5A3};
            @(negedge clk);
            cpol_i = 1'b0; chan_i = 1'b0; single_i = 1'b1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            falls_before = cs_falls;
            repeat (40) @(negedge clk);
            chan_i = 1'b1; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            wait_valid();
            chk("R8 channel kept", result_chan_o, 0);
            chk("R8 single frame edges", rcnt, 24);
            chk("R8 result intact", result_o, 12'h5A3);
            repeat (30) @(negedge clk);
            chk("R8 no new frame", cs_falls - falls_before, 0);
            chk("R8 chip select idle", csn_o, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule